// File: doc/BRIEF.md
# UART Address and Character Matcher

This block sits beside a UART receiver and looks at each finished character once, on a one-cycle valid strobe. While the receiver is muted it treats a character as an address candidate only when its address-mark bit is set. It then compares either the low nibble or the low seven bits against a programmed match value, and a hit produces a single-cycle wakeup pulse that the mute sequencer uses to leave mute. While the receiver is not muted it compares the whole character against the match value instead, and a hit sets a sticky match flag that software clears with a strobe.

The match value and the address-width selection live in two small configuration registers. Each one takes writes only while the relevant enables are low, so the compare setup cannot change under a running receiver. Bit sampling, baud timing and the rest of the mute state machine are outside this block.

Top module: `uart_addr_char_match`

## Requirements
- R1: After reset the wakeup pulse and match flag are 0, the match value is 0x00 and the address width is 4-bit (width select 0).
- R2: With width select 0, mute active and an 8-bit character, a character with bit 7 set whose bits 3:0 equal match value bits 3:0 raises the wakeup pulse in the cycle after the valid strobe.
- R3: With width select 1, mute active and an 8-bit character, a character with bit 7 set whose bits 6:0 equal match value bits 6:0 raises the wakeup pulse. A character that agrees only in bits 3:0 does not.
- R4: The address-mark bit is bit 7 for 8-bit characters and bit 6 for 7-bit characters. A character whose mark bit is 0 never produces a wakeup pulse.
- R5: For a 7-bit character (full-width indication 0), width select 1 falls back to the 4-bit comparison of bits 3:0.
- R6: With mute inactive, the match flag sets in the cycle after the strobe when the received character equals the match value: all 8 bits for an 8-bit character, bits 6:0 for a 7-bit character. No wakeup pulse is produced.
- R7: With mute active, the match flag is never set.
- R8: The match flag stays set until a clear strobe. If a clear and a new match arrive in the same cycle, the flag stays set.
- R9: A match-value write takes effect only while the receive enable or the peripheral enable is 0. Otherwise it is ignored.
- R10: An address-width write takes effect only while the peripheral enable is 0. Otherwise it is ignored.
- R11: The wakeup pulse lasts exactly one cycle per matching address character. With no valid strobe, neither output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| periph_en | input | 1 | Peripheral enable |
| rx_en | input | 1 | Receiver enable |
| match_wr | input | 1 | Write strobe for the match value |
| match_wdata | input | 8 | New match value |
| width_wr | input | 1 | Write strobe for the address-width select |
| width_wdata | input | 1 | New width select: 0 = 4-bit, 1 = 7-bit |
| char_valid | input | 1 | One-cycle strobe: a received character is ready |
| char_data | input | 8 | Received character |
| char_is_full | input | 1 | 1 = 8-bit character mode, 0 = 7-bit |
| mute_active | input | 1 | Receiver is in mute mode |
| match_flag_clr | input | 1 | Clear strobe for the match flag |
| wake_pulse | output | 1 | One-cycle address-match wakeup |
| match_flag | output | 1 | Sticky character-match flag |

## Verification
The bench uses characters that agree with the match value in the low nibble but not in bits 6:0. A design that ignored the width select, or applied it to 7-bit characters, would raise the wakeup pulse when it should not, or miss it. Characters with a clear mark bit but a matching payload expose a design that skips the mark check or reads the mark from the wrong bit. Writes attempted while the enables are high are followed by characters that only the old configuration would match, so a lock that leaks shows up as a wrong match. A clear issued in the same cycle as a new match catches a design that gives the clear priority.

// File: rtl/uacm_pkg.sv
package uacm_pkg;
   typedef enum logic {
      ADDR_NARROW = 1'b0,
      ADDR_WIDE   = 1'b1
   } addr_width_e;

   typedef struct packed {
      logic addr_hit;
      logic char_hit;
   } cmp_result_t;
endpackage

// File: rtl/uacm_cfg_regs.sv
module uacm_cfg_regs
   import uacm_pkg::*;
#(
   parameter int CHAR_W = 8,
   parameter logic [CHAR_W-1:0] MATCH_RST = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              periph_en,
   input  logic              rx_en,
   input  logic              match_wr,
   input  logic [CHAR_W-1:0] match_wdata,
   input  logic              width_wr,
   input  logic              width_wdata,
   output logic [CHAR_W-1:0] match_q,
   output addr_width_e       width_q
);
   logic match_open;
   logic width_open;

   assign match_open = !rx_en || !periph_en;
   assign width_open = !periph_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_q <= MATCH_RST;
         width_q <= ADDR_NARROW;
      end else begin
         if (match_wr && match_open) match_q <= match_wdata;
         if (width_wr && width_open) width_q <= addr_width_e'(width_wdata);
      end
   end

   AST_MATCH_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (match_wr && rx_en && periph_en) |=> $stable(match_q)); // R9
   AST_MATCH_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (match_wr && (!rx_en || !periph_en)) |=> (match_q == $past(match_wdata))); // R9
   AST_WIDTH_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (width_wr && periph_en) |=> $stable(width_q)); // R10
   AST_WIDTH_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (width_wr && !periph_en) |=> (width_q == addr_width_e'($past(width_wdata)))); // R10
endmodule

// File: rtl/uacm_compare.sv
module uacm_compare
   import uacm_pkg::*;
#(
   parameter int CHAR_W   = 8,
   parameter int NARROW_W = 4
) (
   input  logic [CHAR_W-1:0] match_q,
   input  addr_width_e       width_q,
   input  logic [CHAR_W-1:0] char_data,
   input  logic              char_is_full,
   output cmp_result_t       result
);
   localparam int WIDE_W  = CHAR_W - 1;
   localparam int SHORT_W = CHAR_W - 1;

   if (NARROW_W < 1 || NARROW_W >= WIDE_W) begin : g_bad_narrow
      $error("NARROW_W must lie between 1 and CHAR_W-2");
   end
   if (CHAR_W < 4) begin : g_bad_char
      $error("CHAR_W must be at least 4");
   end

   logic [CHAR_W-1:0] narrow_mask;
   logic [CHAR_W-1:0] wide_mask;
   logic [CHAR_W-1:0] short_mask;

   for (genvar i = 0; i < CHAR_W; i++) begin : g_mask
      assign narrow_mask[i] = (i < NARROW_W);
      assign wide_mask[i]   = (i < WIDE_W);
      assign short_mask[i]  = (i < SHORT_W);
   end

   logic              mark;
   logic              use_wide;
   logic [CHAR_W-1:0] diff;
   logic [CHAR_W-1:0] addr_mask;
   logic [CHAR_W-1:0] char_mask;

   always_comb begin
      mark      = char_is_full ? char_data[CHAR_W-1] : char_data[CHAR_W-2];
      use_wide  = (width_q == ADDR_WIDE) && char_is_full;
      diff      = char_data ^ match_q;
      addr_mask = use_wide ? wide_mask : narrow_mask;
      char_mask = char_is_full ? '1 : short_mask;
      result.addr_hit = mark && ((diff & addr_mask) == '0);
      result.char_hit = ((diff & char_mask) == '0);
   end
endmodule

// File: rtl/uacm_event_ctrl.sv
module uacm_event_ctrl
   import uacm_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        char_valid,
   input  logic        mute_active,
   input  cmp_result_t cmp,
   input  logic        flag_clr,
   output logic        wake_pulse,
   output logic        match_flag
);
   logic wake_set;
   logic flag_set;

   assign wake_set = char_valid && mute_active && cmp.addr_hit;
   assign flag_set = char_valid && !mute_active && cmp.char_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wake_pulse <= 1'b0;
         match_flag <= 1'b0;
      end else begin
         wake_pulse <= wake_set;
         if (flag_set)      match_flag <= 1'b1;
         else if (flag_clr) match_flag <= 1'b0;
      end
   end

   AST_WAKE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |-> $past(char_valid && mute_active)); // R11
   AST_NO_WAKE_UNMUTED: assert property (@(posedge clk) disable iff (!rst_n)
      !mute_active |=> !wake_pulse); // R6
   AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_set && flag_clr) |=> match_flag); // R8
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (match_flag && !flag_clr) |=> match_flag); // R8
   AST_NO_FLAG_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
      (!match_flag && (mute_active || !char_valid)) |=> !match_flag); // R7
endmodule

// File: rtl/uart_addr_char_match.sv
module uart_addr_char_match
   import uacm_pkg::*;
#(
   parameter int CHAR_W   = 8,
   parameter int NARROW_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              periph_en,
   input  logic              rx_en,
   input  logic              match_wr,
   input  logic [CHAR_W-1:0] match_wdata,
   input  logic              width_wr,
   input  logic              width_wdata,
   input  logic              char_valid,
   input  logic [CHAR_W-1:0] char_data,
   input  logic              char_is_full,
   input  logic              mute_active,
   input  logic              match_flag_clr,
   output logic              wake_pulse,
   output logic              match_flag
);
   logic [CHAR_W-1:0] match_q;
   addr_width_e       width_q;
   cmp_result_t       cmp;

   uacm_cfg_regs #(.CHAR_W(CHAR_W), .MATCH_RST('0)) cfg_i (
      .clk(clk), .rst_n(rst_n), .periph_en(periph_en), .rx_en(rx_en),
      .match_wr(match_wr), .match_wdata(match_wdata),
      .width_wr(width_wr), .width_wdata(width_wdata),
      .match_q(match_q), .width_q(width_q)
   );

   uacm_compare #(.CHAR_W(CHAR_W), .NARROW_W(NARROW_W)) cmp_i (
      .match_q(match_q), .width_q(width_q), .char_data(char_data),
      .char_is_full(char_is_full), .result(cmp)
   );

   uacm_event_ctrl evt_i (
      .clk(clk), .rst_n(rst_n), .char_valid(char_valid),
      .mute_active(mute_active), .cmp(cmp), .flag_clr(match_flag_clr),
      .wake_pulse(wake_pulse), .match_flag(match_flag)
   );

   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!wake_pulse && !match_flag)); // R1
endmodule

// File: tb/uart_addr_char_match_tb_top.sv
module uart_addr_char_match_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic periph_en = 1'b0, rx_en = 1'b0;
   logic match_wr = 1'b0, width_wr = 1'b0, width_wdata = 1'b0;
   logic [7:0] match_wdata = '0, char_data = '0;
   logic char_valid = 1'b0, char_is_full = 1'b1, mute_active = 1'b0, match_flag_clr = 1'b0;
   logic wake_pulse, match_flag;
   int errors = 0, checks = 0;

   always #10 clk = ~clk;

   uart_addr_char_match dut_i (.*);

   // fields: [16:13] req, [12] wide, [11] mute, [10] full, [9:2] data, [1] wake, [0] flag
   localparam int NV = 15;
   localparam logic [16:0] VEC [NV] = '{
      {4'd2,  1'b0, 1'b1, 1'b1, 8'h85, 1'b1, 1'b0},  // R2 nibble hit
      {4'd2,  1'b0, 1'b1, 1'b1, 8'hF5, 1'b1, 1'b0},  // R2
      {4'd4,  1'b0, 1'b1, 1'b1, 8'h05, 1'b0, 1'b0},  // R4 mark clear
      {4'd2,  1'b0, 1'b1, 1'b1, 8'h86, 1'b0, 1'b0},  // R2 nibble miss
      {4'd3,  1'b1, 1'b1, 1'b1, 8'hA5, 1'b1, 1'b0},  // R3 seven-bit hit
      {4'd3,  1'b1, 1'b1, 1'b1, 8'h85, 1'b0, 1'b0},  // R3 nibble only
      {4'd4,  1'b1, 1'b1, 1'b1, 8'h25, 1'b0, 1'b0},  // R4
      {4'd5,  1'b1, 1'b1, 1'b0, 8'h45, 1'b1, 1'b0},  // R5 fallback
      {4'd4,  1'b1, 1'b1, 1'b0, 8'h05, 1'b0, 1'b0},  // R4 bit 6 mark
      {4'd6,  1'b0, 1'b0, 1'b1, 8'hA5, 1'b0, 1'b1},  // R6 full hit
      {4'd6,  1'b0, 1'b0, 1'b1, 8'hA4, 1'b0, 1'b0},  // R6 miss
      {4'd7,  1'b0, 1'b1, 1'b1, 8'hA5, 1'b1, 1'b0},  // R7 no flag muted
      {4'd6,  1'b0, 1'b0, 1'b0, 8'h25, 1'b0, 1'b1},  // R6 short char
      {4'd6,  1'b1, 1'b0, 1'b1, 8'h25, 1'b0, 1'b0},  // R6 bit 7 differs
      {4'd6,  1'b0, 1'b0, 1'b0, 8'hA4, 1'b0, 1'b0}   // R6 short miss
   };

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic write_match(input logic [7:0] v);
      @(negedge clk); match_wr = 1'b1; match_wdata = v;
      @(negedge clk); match_wr = 1'b0;
   endtask

   task automatic write_width(input logic v);
      @(negedge clk); width_wr = 1'b1; width_wdata = v;
      @(negedge clk); width_wr = 1'b0;
   endtask

   // drives one character; returns the outputs one cycle later and the pulse the cycle after
   task automatic send(input logic mute, input logic full, input logic [7:0] d,
                       output logic w1, output logic f1, output logic w2);
      @(negedge clk);
      mute_active = mute; char_is_full = full; char_data = d; char_valid = 1'b1;
      @(negedge clk);
      char_valid = 1'b0;
      w1 = wake_pulse; f1 = match_flag;
      @(negedge clk);
      w2 = wake_pulse;
   endtask

   task automatic clear_flag();
      @(negedge clk); match_flag_clr = 1'b1;
      @(negedge clk); match_flag_clr = 1'b0;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic w1, f1, w2;
      logic cur_wide;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 wake after reset", wake_pulse, 1'b0);
      chk("R1 flag after reset", match_flag, 1'b0);
      periph_en = 1'b1; rx_en = 1'b1;
      // reset match value 0x00 and 4-bit width: 0x80 wakes, 0x00 full-matches
      send(1'b1, 1'b1, 8'h80, w1, f1, w2);
      chk("R1 reset config wake", w1, 1'b1);
      send(1'b0, 1'b1, 8'h00, w1, f1, w2);
      chk("R1 reset match value", f1, 1'b1);
      clear_flag();
      chk("R8 clear strobe", match_flag, 1'b0);

      // table setup
      rx_en = 1'b0;
      write_match(8'hA5);
      rx_en = 1'b1;
      cur_wide = 1'b0;
      for (int i = 0; i < NV; i++) begin
         if (VEC[i][12] != cur_wide) begin
            periph_en = 1'b0;
            write_width(VEC[i][12]);
            periph_en = 1'b1;
            cur_wide = VEC[i][12];
         end
         send(VEC[i][11], VEC[i][10], VEC[i][9:2], w1, f1, w2);
         chk($sformatf("vector %0d (R%0d) wake", i, VEC[i][16:13]), w1, VEC[i][1]);
         chk($sformatf("vector %0d (R%0d) flag", i, VEC[i][16:13]), f1, VEC[i][0]);
         chk($sformatf("vector %0d R11 pulse length", i), w2, 1'b0);
         clear_flag();
      end

      // R9: locked write ignored, open write taken
      periph_en = 1'b0; write_width(1'b0); periph_en = 1'b1;
      write_match(8'h3C);
      send(1'b0, 1'b1, 8'hA5, w1, f1, w2);
      chk("R9 locked match write ignored", f1, 1'b1);
      clear_flag();
      rx_en = 1'b0; write_match(8'h3C); rx_en = 1'b1;
      send(1'b0, 1'b1, 8'h3C, w1, f1, w2);
      chk("R9 open match write taken", f1, 1'b1);
      clear_flag();

      // R10: width write ignored while enabled
      write_match(8'h3C);
      rx_en = 1'b0; write_match(8'hA5); rx_en = 1'b1;
      write_width(1'b1);
      send(1'b1, 1'b1, 8'h85, w1, f1, w2);
      chk("R10 locked width write ignored", w1, 1'b1);
      periph_en = 1'b0; write_width(1'b1); periph_en = 1'b1;
      send(1'b1, 1'b1, 8'h85, w1, f1, w2);
      chk("R10 open width write taken", w1, 1'b0);

      // R8: sticky and set-beats-clear
      send(1'b0, 1'b1, 8'hA5, w1, f1, w2);
      repeat (4) @(negedge clk);
      chk("R8 flag stays set", match_flag, 1'b1);
      clear_flag();
      @(negedge clk);
      mute_active = 1'b0; char_is_full = 1'b1; char_data = 8'hA5;
      char_valid = 1'b1; match_flag_clr = 1'b1;
      @(negedge clk);
      char_valid = 1'b0; match_flag_clr = 1'b0;
      chk("R8 set wins over clear", match_flag, 1'b1);
      clear_flag();

      // R11: quiet with no strobe even though data would match
      mute_active = 1'b1; char_data = 8'hA5;
      repeat (3) @(negedge clk);
      chk("R11 no wake without strobe", wake_pulse, 1'b0);
      chk("R11 no flag without strobe", match_flag, 1'b0);
      finish_run();
   end
endmodule